// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. It samples eight request inputs and stores them in a request register. Each line can be edge triggered, where a rising edge latches a request, or level triggered, where the stored bit follows the input. A mask register removes lines from consideration. An in-service register records the lines the processor is currently handling. A three-bit priority base sets which line currently has the highest priority.

The block raises a registered interrupt output when the best unmasked request has a higher priority than the best line already in service. On an acknowledge strobe it reports the winning line and updates the in-service, request and base state, following the end-of-interrupt mode selected by its inputs. A separate command decoder drives all register loads as single-cycle pulses. Vector formation, cascading and the bus interface are not part of this block.

Top module: `irq_resolver`

## Requirements
- R1: After reset, irq_out, ack_hit and ack_line are 0, and the request, mask, in-service and last-sample registers are all 0. The base is 0 and every line is edge triggered (trigger bit 0).
- R2: Only lines whose request bit is 1 and whose mask bit is 0 can win. A mask bit of 1 keeps its line from raising irq_out or winning an acknowledge.
- R3: A line's rank is (line - base) mod 8, and a lower rank means higher priority. irq_out is raised only when the lowest-ranked candidate has a rank strictly below the lowest rank among the in-service bits. An empty in-service register counts as rank 8.
- R4: On ack, ack_hit and ack_line are updated on the next clock. When a winner exists, ack_hit=1 and ack_line is the winning line, equal to (rank + base) mod 8. When no winner exists, ack_hit=0 and ack_line=7. Both outputs hold their value between acks.
- R5: An edge-triggered line sets its request bit only when the input is 1 and the previous sample was 0. An input held at 1 does not re-request after the bit has been cleared.
- R6: On an acknowledge with a winner and auto_eoi=0, the in-service bit of the winning line is set.
- R7: On an acknowledge with a winner and auto_eoi=1, no in-service bit is set. If rot_on_aeoi=1 as well, the base becomes (line + 1) mod 8.
- R8: An acknowledge with a winner clears the winner's request bit only if the line is edge triggered. A level-triggered request bit follows the input every cycle and is kept through the acknowledge.
- R9: When nest_en=1 and the block is the master (IS_MASTER=1), in-service bit 2 is ignored in the in-service rank.
- R10: irq_out is registered. It reflects the register state of the previous cycle, so a new request input shows on irq_out two clocks later.
- R11: An isr_clr pulse clears the in-service bit selected by isr_clr_line. A base_ld pulse loads base_d into the base and takes precedence over a rotation in the same cycle.
- R12: A mask_ld pulse loads mask_d into the mask register. A trig_ld pulse loads trig_d into the trigger register, where bit value 1 means level triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 8 | Request inputs, one per line |
| mask_ld | input | 1 | Load pulse for the mask register |
| mask_d | input | 8 | New mask value (1 = masked) |
| trig_ld | input | 1 | Load pulse for the trigger register |
| trig_d | input | 8 | New trigger value (1 = level) |
| base_ld | input | 1 | Load pulse for the priority base |
| base_d | input | 3 | New base line |
| isr_clr | input | 1 | Pulse clearing one in-service bit |
| isr_clr_line | input | 3 | Line whose in-service bit is cleared |
| auto_eoi | input | 1 | Auto end-of-interrupt mode |
| rot_on_aeoi | input | 1 | Rotate the base on auto end-of-interrupt |
| nest_en | input | 1 | Exclude in-service bit 2 from nesting (master only) |
| ack | input | 1 | Acknowledge strobe |
| irq_out | output | 1 | Registered interrupt request to the processor |
| ack_hit | output | 1 | Last acknowledge found a winner |
| ack_line | output | 3 | Line reported by the last acknowledge |

## Verification
A wrong base or a wrong in-service bit changes the line order. It shows at the next acknowledge as the wrong ack_line, or within two clocks as irq_out raised or held low against the nesting rule. A stale request bit shows up as a repeated winner or a spurious ack_hit on the following acknowledge. The bench therefore sweeps every base against every request pattern, and it compares a cycle-accurate model of its own against irq_out, ack_hit and ack_line on every cycle under mixed stimulus.

// File: rtl/rpir_pkg.sv
package rpir_pkg;
  localparam int LINE_W = 3;
  localparam int LINES  = 1 << LINE_W;

  typedef logic [LINES-1:0]  line_vec_t;
  typedef logic [LINE_W-1:0] line_id_t;
  typedef logic [LINE_W:0]   rank_t;

  // Lowest offset from base whose bit is set; LINES when none.
  function automatic rank_t rot_first(line_vec_t vec, line_id_t base);
    rank_t    r;
    line_id_t idx;
    r = rank_t'(LINES);
    for (int off = LINES - 1; off >= 0; off--) begin
      idx = line_id_t'(off) + base;
      if (vec[idx]) r = rank_t'(off);
    end
    return r;
  endfunction

  function automatic line_id_t rank_to_line(rank_t r, line_id_t base);
    return r[LINE_W-1:0] + base;
  endfunction

  function automatic line_vec_t line_bit(line_id_t id);
    return line_vec_t'(1) << id;
  endfunction
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank
  import rpir_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t req_in,
  input  line_vec_t trig_lvl,
  input  line_vec_t clr_vec,
  output line_vec_t irr
);
  line_vec_t last_q;
  line_vec_t irr_q;
  line_vec_t rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= req_in;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign rise[g] = req_in[g] & ~last_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           irr_q[g] <= 1'b0;
      else if (trig_lvl[g]) irr_q[g] <= req_in[g];
      else                  irr_q[g] <= rise[g] | (irr_q[g] & ~clr_vec[g]);
    end

    // R8: an acknowledged edge line drops its request unless a new edge arrives
    p_edge_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[g] && !trig_lvl[g] && !(req_in[g] && !last_q[g])) |=> !irr_q[g]);

    // R5: a held-high edge input does not re-request
    p_edge_no_retrig_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_lvl[g] && last_q[g] && req_in[g] && !irr_q[g]) |=> !irr_q[g]);
  end

  assign irr = irr_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import rpir_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  parameter int NEST_LINE = 2
) (
  input  line_vec_t irr,
  input  line_vec_t imr,
  input  line_vec_t isr,
  input  line_id_t  base,
  input  logic      nest_en,
  output logic      want,
  output line_id_t  win_line
);
  line_vec_t cand;
  line_vec_t isr_eff;
  rank_t     req_rank;
  rank_t     svc_rank;

  assign cand = irr & ~imr;

  if (IS_MASTER) begin : g_master
    always_comb begin
      isr_eff = isr;
      if (nest_en) isr_eff[NEST_LINE] = 1'b0;
    end
  end else begin : g_slave
    assign isr_eff = isr;
  end

  assign req_rank = rot_first(cand, base);
  assign svc_rank = rot_first(isr_eff, base);
  assign want     = req_rank < svc_rank;
  assign win_line = rank_to_line(req_rank, base);
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import rpir_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  parameter int NEST_LINE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  req_in,
  input  logic              mask_ld,
  input  logic [LINES-1:0]  mask_d,
  input  logic              trig_ld,
  input  logic [LINES-1:0]  trig_d,
  input  logic              base_ld,
  input  logic [LINE_W-1:0] base_d,
  input  logic              isr_clr,
  input  logic [LINE_W-1:0] isr_clr_line,
  input  logic              auto_eoi,
  input  logic              rot_on_aeoi,
  input  logic              nest_en,
  input  logic              ack,
  output logic              irq_out,
  output logic              ack_hit,
  output logic [LINE_W-1:0] ack_line
);
  line_vec_t imr_q, trig_q, isr_q, irr;
  line_id_t  base_q;
  logic      irq_q, hit_q;
  line_id_t  line_q;

  // Named internal events
  logic      want;
  line_id_t  win_line;
  logic      ack_take;
  logic      rot_fire;
  line_vec_t ack_clr_vec;
  line_vec_t isr_set_mask;
  line_vec_t isr_clr_mask;

  assign ack_take     = ack & want;
  assign rot_fire     = ack_take & auto_eoi & rot_on_aeoi;
  assign ack_clr_vec  = ack_take ? line_bit(win_line) : '0;
  assign isr_set_mask = (ack_take && !auto_eoi) ? line_bit(win_line) : '0;
  assign isr_clr_mask = isr_clr ? line_bit(isr_clr_line) : '0;

  irq_req_bank u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_in   (req_in),
    .trig_lvl (trig_q),
    .clr_vec  (ack_clr_vec),
    .irr      (irr)
  );

  irq_prio_sel #(
    .IS_MASTER (IS_MASTER),
    .NEST_LINE (NEST_LINE)
  ) u_sel (
    .irr      (irr),
    .imr      (imr_q),
    .isr      (isr_q),
    .base     (base_q),
    .nest_en  (nest_en),
    .want     (want),
    .win_line (win_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q  <= '0;
      trig_q <= '0;
      isr_q  <= '0;
      base_q <= '0;
      irq_q  <= 1'b0;
      hit_q  <= 1'b0;
      line_q <= '0;
    end else begin
      if (mask_ld) imr_q  <= mask_d;
      if (trig_ld) trig_q <= trig_d;
      isr_q <= (isr_q & ~isr_clr_mask) | isr_set_mask;
      if (base_ld)       base_q <= base_d;
      else if (rot_fire) base_q <= win_line + line_id_t'(1);
      irq_q <= want;
      if (ack) begin
        hit_q  <= want;
        line_q <= want ? win_line : line_id_t'(LINES - 1);
      end
    end
  end

  assign irq_out  = irq_q;
  assign ack_hit  = hit_q;
  assign ack_line = line_q;

  // R2: no unmasked request means no interrupt next cycle
  p_irq_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(irr & ~imr_q)) |=> !irq_out);

  // R4: an acknowledge with no candidate reports no hit
  p_spurious_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(|(irr & ~imr_q))) |=> (!ack_hit && ack_line == line_id_t'(LINES - 1)));

  // R6: reported line becomes in service without auto end-of-interrupt
  p_ack_sets_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && want && !auto_eoi) |=> isr_q[ack_line]);

  // R7: auto end-of-interrupt leaves in-service bits alone
  p_aeoi_isr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && auto_eoi && !isr_clr) |=> (isr_q == $past(isr_q)));

  // R7: rotation moves the base just past the reported line
  p_rotate_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && want && auto_eoi && rot_on_aeoi && !base_ld) |=> (base_q == ack_line + line_id_t'(1)));

  // R8: a level line with its input still high keeps its request
  p_level_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && want && trig_q[win_line] && req_in[win_line]) |=> irr[ack_line]);
endmodule

// File: tb/irq_resolver_test.sv
`timescale 1ns/1ps
module irq_resolver_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] req_in = '0, mask_d = '0, trig_d = '0;
  logic mask_ld = 0, trig_ld = 0, base_ld = 0, isr_clr = 0;
  logic [2:0] base_d = '0, isr_clr_line = '0;
  logic auto_eoi = 0, rot_on_aeoi = 0, nest_en = 0, ack = 0;
  logic irq_out, ack_hit;
  logic [2:0] ack_line;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_resolver uut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in),
    .mask_ld(mask_ld), .mask_d(mask_d), .trig_ld(trig_ld), .trig_d(trig_d),
    .base_ld(base_ld), .base_d(base_d), .isr_clr(isr_clr), .isr_clr_line(isr_clr_line),
    .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi), .nest_en(nest_en), .ack(ack),
    .irq_out(irq_out), .ack_hit(ack_hit), .ack_line(ack_line)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; req_in = '0; mask_ld = 0; trig_ld = 0; base_ld = 0; isr_clr = 0;
    auto_eoi = 0; rot_on_aeoi = 0; nest_en = 0; ack = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic ack_once();
    ack = 1; step(1); ack = 0;
  endtask

  task automatic clear_isr(int line);
    isr_clr = 1; isr_clr_line = 3'(line); step(1); isr_clr = 0;
  endtask

  // Independent priority model: rank of each line relative to the base
  function automatic int bench_rank(logic [7:0] vec, int base);
    int best = 8;
    for (int l = 0; l < 8; l++)
      if (vec[l] && ((l - base + 8) % 8) < best) best = (l - base + 8) % 8;
    return best;
  endfunction

  // Cycle model
  logic mdl_on = 0;
  logic [7:0] m_irr, m_imr, m_isr, m_trig, m_last;
  logic [2:0] m_base, m_line;
  logic m_irq, m_hit;

  always @(posedge clk) begin
    int rr, sr, wl;
    logic w;
    logic [7:0] ie, nirr;
    if (mdl_on) begin
      rr = bench_rank(m_irr & ~m_imr, int'(m_base));
      ie = m_isr;
      if (nest_en) ie[2] = 1'b0;
      sr = bench_rank(ie, int'(m_base));
      w  = rr < sr;
      wl = (rr + int'(m_base)) % 8;
      m_irq <= w;
      if (ack) begin
        m_hit  <= w;
        m_line <= w ? 3'(wl) : 3'd7;
      end
      for (int l = 0; l < 8; l++) begin
        if (m_trig[l]) nirr[l] = req_in[l];
        else nirr[l] = (req_in[l] & ~m_last[l]) | (m_irr[l] & ~(ack && w && wl == l));
      end
      m_irr  <= nirr;
      m_last <= req_in;
      ie = m_isr;
      if (isr_clr) ie[isr_clr_line] = 1'b0;
      if (ack && w && !auto_eoi) ie[wl] = 1'b1;
      m_isr <= ie;
      if (mask_ld) m_imr <= mask_d;
      if (trig_ld) m_trig <= trig_d;
      if (base_ld) m_base <= base_d;
      else if (ack && w && auto_eoi && rot_on_aeoi) m_base <= 3'((wl + 1) % 8);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 irq_out", int'(irq_out), 0);
    chk("R1 ack_hit", int'(ack_hit), 0);
    chk("R1 ack_line", int'(ack_line), 0);
    ack_once();
    chk("R1 empty after reset", int'(ack_hit), 0);

    // R10 latency, R3 nesting, R6 in-service set, R11 clear
    do_reset();
    req_in = 8'h20; step(1);
    chk("R10 irq one clock", int'(irq_out), 0);
    step(1);
    chk("R10 irq two clocks", int'(irq_out), 1);
    ack_once();
    chk("R4 hit", int'(ack_hit), 1);
    chk("R4 line5", int'(ack_line), 5);
    step(1);
    chk("R6 line5 in service", int'(irq_out), 0);
    req_in = 8'h60; step(2);
    chk("R3 lower blocked", int'(irq_out), 0);
    req_in = 8'h68; step(2);
    chk("R3 higher nests", int'(irq_out), 1);
    ack_once();
    chk("R4 line3", int'(ack_line), 3);
    clear_isr(3); step(2);
    chk("R11 line5 still blocks", int'(irq_out), 0);
    clear_isr(5); step(2);
    chk("R11 cleared", int'(irq_out), 1);
    ack_once();
    chk("R4 line6", int'(ack_line), 6);
    clear_isr(6); step(2);
    chk("R5 held high no retrigger", int'(irq_out), 0);
    ack_once();
    chk("R4 spurious hit", int'(ack_hit), 0);
    chk("R4 spurious line", int'(ack_line), 7);
    req_in = 8'h00; step(1);
    req_in = 8'h40; step(2);
    chk("R5 new edge", int'(irq_out), 1);

    // R2 mask, R12 loads, R8 level retention
    do_reset();
    trig_d = 8'hFF; trig_ld = 1; mask_d = 8'h10; mask_ld = 1; step(1);
    trig_ld = 0; mask_ld = 0;
    req_in = 8'h10; step(3);
    chk("R2 masked", int'(irq_out), 0);
    ack_once();
    chk("R2 masked ack", int'(ack_hit), 0);
    mask_d = 8'h00; mask_ld = 1; step(1); mask_ld = 0; step(1);
    chk("R12 unmasked", int'(irq_out), 1);
    auto_eoi = 1;
    ack_once();
    chk("R8 line4", int'(ack_line), 4);
    step(2);
    chk("R8 level kept", int'(irq_out), 1);
    req_in = 8'h00; step(2);
    chk("R8 level follows", int'(irq_out), 0);

    // R7 rotation, R11 base load
    rot_on_aeoi = 1; req_in = 8'h81; step(2);
    ack_once(); chk("R7 first", int'(ack_line), 0);
    ack_once(); chk("R7 rotated", int'(ack_line), 7);
    ack_once(); chk("R7 wrapped", int'(ack_line), 0);
    rot_on_aeoi = 0;
    base_d = 3'd7; base_ld = 1; step(1); base_ld = 0;
    ack_once(); chk("R11 base load", int'(ack_line), 7);

    // R9 nesting exclusion of line 2
    do_reset();
    req_in = 8'h04; step(2);
    ack_once(); chk("R9 line2", int'(ack_line), 2);
    req_in = 8'h00; step(1);
    req_in = 8'h04; step(2);
    chk("R9 off blocks", int'(irq_out), 0);
    nest_en = 1; step(2);
    chk("R9 on allows", int'(irq_out), 1);
    ack_once(); chk("R9 ack", int'(ack_hit), 1);
    nest_en = 0;

    // R2/R4 exhaustive sweep: every base against every pattern
    do_reset();
    trig_d = 8'hFF; trig_ld = 1; step(1); trig_ld = 0;
    auto_eoi = 1;
    for (int b = 0; b < 8; b++) begin
      for (int p = 0; p < 256; p++) begin
        int r;
        req_in = 8'(p); base_d = 3'(b); base_ld = 1; step(1);
        base_ld = 0;
        ack_once();
        r = bench_rank(8'(p), b);
        chk("R4 sweep hit", int'(ack_hit), (p != 0) ? 1 : 0);
        chk("R2 sweep line", int'(ack_line), (p != 0) ? (r + b) % 8 : 7);
      end
    end

    // R3/R4 mixed stimulus against the cycle model
    do_reset();
    m_irr = '0; m_imr = '0; m_isr = '0; m_trig = '0; m_last = '0;
    m_base = '0; m_line = '0; m_irq = 0; m_hit = 0;
    mdl_on = 1;
    for (int c = 0; c < 6000; c++) begin
      if (c > 0) begin
        chk("R3 model irq", int'(irq_out), int'(m_irq));
        chk("R4 model hit", int'(ack_hit), int'(m_hit));
        chk("R4 model line", int'(ack_line), int'(m_line));
      end
      if ((c % 8) == 0) req_in = 8'($urandom);
      ack = ($urandom % 4) == 0;
      mask_ld = ($urandom % 16) == 0; mask_d = 8'($urandom) & 8'($urandom);
      trig_ld = ($urandom % 16) == 0; trig_d = 8'($urandom);
      base_ld = ($urandom % 32) == 0; base_d = 3'($urandom);
      isr_clr = ($urandom % 4) == 0; isr_clr_line = 3'($urandom);
      if ((c % 256) == 0) begin
        auto_eoi = 1'($urandom); rot_on_aeoi = 1'($urandom); nest_en = 1'($urandom);
      end
      step(1);
    end
    mdl_on = 0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule